// File: doc/BRIEF.md
# Indirect Memory Access Controller

This block gives a host access to a set of internal lookup memories without mapping them into the host's address space. The host first writes an address word and loads the data registers. It then writes a command word. The controller moves the entry between the data registers and the selected memory, one 32-bit word per cycle. When it finishes, it sets the status bit that matches the command. The host polls that bit.

The top four bits of the address word choose the memory. The remaining bits give the entry number. There is one packet memory for each parser, plus a shared node memory, a shared search memory and a shared result memory. Each memory has its own fixed entry size in words. Only write and read commands move data. Any other command, any unknown memory type and any entry number past the end complete at once with an error flag, and no memory changes.

Top module: `indram_ctrl`

## Requirements
- R1: After reset, the address, command, status and all data registers read back as zero.
- R2: Host offsets: 0x04 is the address word, 0x08 the command, 0x0C the status and 0x10+4j data register j (j = 0..16). Address, command and data registers read back what was last written. Status ignores host writes, and any unmapped offset reads zero.
- R3: Address bits 31:28 select the memory: the packet memory of parser p at code 4p (p below NUM_PARSERS, at most 3), the node memory at 0xC, the search memory at 0xD and the result memory at 0xE. Bits 27:0 give the entry number.
- R4: An entry occupies PKT_WORDS (4) words in a packet memory, TREE_WORDS (17) in the node memory, SRCH_WORDS (8) in the search memory and RES_WORDS (6) in the result memory. An entry always transfers through data registers 0 up to N-1.
- R5: Command code 1 writes data registers 0..N-1 into the addressed entry. Issuing it clears status. On completion, status reads exactly 0x1.
- R6: Command code 2 loads the addressed entry into data registers 0..N-1 and leaves the other data registers unchanged. On completion, status reads exactly 0x2.
- R7: The packet memories of different parsers are separate: the same entry number under two parser codes holds independent contents.
- R8: Any command other than 1 or 2 (including the search codes 8, 16 and 32) completes in the next cycle. Status then holds bit 31 together with the command's bits within mask 0x3B, and no memory changes.
- R9: A write or read whose memory code is unassigned, or whose entry number is ENTRIES or larger, completes in the next cycle with bit 31 plus the command bit, and changes no memory.
- R10: A valid command completes within N+1 cycles of being issued, far inside the host's millisecond-scale timeout.
- R11: While a command is in progress, host writes to the address, command and data registers are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | ADDR_W | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |

## Verification
The in-line assertions check several properties on every cycle. Status stays clear while a transfer runs, and no memory is written while an error status is held. Address and command hold still during a transfer, a successful status has at most one bit set, and the busy window never exceeds the longest entry plus one cycle. The bench scenarios cover the data-level behaviour. They show that contents survive a round trip through each memory and that parser regions stay apart. They also show that a read leaves the upper data registers alone and that rejected commands leave the memories intact.

// File: rtl/indram_pkg.sv
package indram_pkg;
  localparam logic [31:0] OP_WRITE  = 32'h1;
  localparam logic [31:0] OP_READ   = 32'h2;
  localparam logic [31:0] OP_KNOWN  = 32'h3B;
  localparam logic [31:0] ERR_FLAG  = 32'h8000_0000;
  localparam logic [3:0]  KIND_NODE = 4'hC;
  localparam logic [3:0]  KIND_SRCH = 4'hD;
  localparam logic [3:0]  KIND_RES  = 4'hE;
  localparam int          OFF_ADDR  = 'h04;
  localparam int          OFF_CMD   = 'h08;
  localparam int          OFF_STAT  = 'h0C;
  localparam int          OFF_DATA  = 'h10;
  typedef enum logic [1:0] {SQ_IDLE, SQ_WRITE, SQ_READ, SQ_DRAIN} seq_state_t;
endpackage

// File: rtl/indram_mem.sv
module indram_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (re) rdata <= store[addr];
  end
endmodule

// File: rtl/indram_decode.sv
module indram_decode #(
  parameter int NUM_PARSERS = 3,
  parameter int ENTRIES     = 16,
  parameter int PKT_WORDS   = 4,
  parameter int TREE_WORDS  = 17,
  parameter int SRCH_WORDS  = 8,
  parameter int RES_WORDS   = 6,
  parameter int TGT_W       = 3,
  parameter int CNT_W       = 5,
  parameter int IDX_W       = 4
) (
  input  logic [31:0]      addr_word,
  output logic             hit,
  output logic [TGT_W-1:0] tgt,
  output logic [CNT_W-1:0] nwords,
  output logic [IDX_W-1:0] entry
);
  import indram_pkg::*;
  logic [3:0]  kind;
  logic [27:0] idx;
  logic        kind_ok;

  assign kind  = addr_word[31:28];
  assign idx   = addr_word[27:0];
  assign entry = idx[IDX_W-1:0];

  always_comb begin
    kind_ok = 1'b0;
    tgt     = '0;
    nwords  = '0;
    if (kind == KIND_NODE) begin
      kind_ok = 1'b1; tgt = TGT_W'(NUM_PARSERS);     nwords = CNT_W'(TREE_WORDS);
    end else if (kind == KIND_SRCH) begin
      kind_ok = 1'b1; tgt = TGT_W'(NUM_PARSERS + 1); nwords = CNT_W'(SRCH_WORDS);
    end else if (kind == KIND_RES) begin
      kind_ok = 1'b1; tgt = TGT_W'(NUM_PARSERS + 2); nwords = CNT_W'(RES_WORDS);
    end else if (kind[1:0] == 2'b00 && int'(kind[3:2]) < NUM_PARSERS) begin
      kind_ok = 1'b1; tgt = TGT_W'(kind[3:2]);        nwords = CNT_W'(PKT_WORDS);
    end
    hit = kind_ok && (idx < 28'(ENTRIES));
  end
endmodule

// File: rtl/indram_seq.sv
module indram_seq #(
  parameter int CNT_W     = 5,
  parameter int MAX_WORDS = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_wr,
  input  logic             start_rd,
  input  logic [CNT_W-1:0] nwords,
  output logic             busy,
  output logic             mem_we,
  output logic             mem_re,
  output logic [CNT_W-1:0] word_idx,
  output logic             lat_en,
  output logic [CNT_W-1:0] lat_idx,
  output logic             done
);
  import indram_pkg::*;
  seq_state_t      state;
  logic [CNT_W-1:0] cnt;
  logic             last_word;
  logic             lat_last;

  assign busy      = (state != SQ_IDLE);
  assign last_word = (cnt == nwords - CNT_W'(1));
  assign mem_we    = (state == SQ_WRITE);
  assign mem_re    = (state == SQ_READ);
  assign word_idx  = cnt;
  assign done      = (state == SQ_WRITE && last_word) || (lat_en && lat_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      lat_en   <= 1'b0;
      lat_idx  <= '0;
      lat_last <= 1'b0;
    end else begin
      lat_en   <= mem_re;
      lat_idx  <= cnt;
      lat_last <= mem_re && last_word;
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (start_wr)      state <= SQ_WRITE;
          else if (start_rd) state <= SQ_READ;
        end
        SQ_WRITE: begin
          if (last_word) state <= SQ_IDLE;
          else           cnt <= cnt + CNT_W'(1);
        end
        SQ_READ: begin
          if (last_word) state <= SQ_DRAIN;
          else           cnt <= cnt + CNT_W'(1);
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // bounded transfer window (R10), counted rather than unrolled
  logic [CNT_W+1:0] busy_cycles;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cycles <= '0;
    else              busy_cycles <= busy_cycles + 1'b1;
  end

  a_r10_bounded_busy: assert property (@(posedge clk) disable iff (rst)
    busy_cycles <= (CNT_W+2)'(MAX_WORDS + 1));
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && lat_en));
endmodule

// File: rtl/indram_ctrl.sv
module indram_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int NUM_PARSERS = 3,
  parameter int ENTRIES     = 16,
  parameter int PKT_WORDS   = 4,
  parameter int TREE_WORDS  = 17,
  parameter int SRCH_WORDS  = 8,
  parameter int RES_WORDS   = 6,
  parameter int DATA_REGS   = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  import indram_pkg::*;

  localparam int NUM_TGT   = NUM_PARSERS + 3;
  localparam int TGT_W     = $clog2(NUM_TGT);
  localparam int MAX_A     = (PKT_WORDS > TREE_WORDS) ? PKT_WORDS : TREE_WORDS;
  localparam int MAX_B     = (SRCH_WORDS > RES_WORDS) ? SRCH_WORDS : RES_WORDS;
  localparam int MAX_WORDS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int MEM_AW    = $clog2(ENTRIES * MAX_WORDS);

  logic [31:0]       addr_q, cmd_q, status_q;
  logic [31:0]       data_q [DATA_REGS];
  logic [TGT_W-1:0]  tgt_q;
  logic [CNT_W-1:0]  nwords_q;
  logic [MEM_AW-1:0] base_q;

  logic              dec_hit;
  logic [TGT_W-1:0]  dec_tgt;
  logic [CNT_W-1:0]  dec_nwords;
  logic [IDX_W-1:0]  dec_entry;

  logic              busy, seq_we, seq_re, lat_en, done;
  logic [CNT_W-1:0]  word_idx, lat_idx;
  logic              host_wr, cmd_wr, cmd_good, start_wr, start_rd;
  logic [31:0]       rd_arr [NUM_TGT];
  logic [31:0]       rd_sel;
  logic [MEM_AW-1:0] mem_addr;
  logic [NUM_TGT-1:0] we_vec;

  indram_decode #(
    .NUM_PARSERS(NUM_PARSERS), .ENTRIES(ENTRIES), .PKT_WORDS(PKT_WORDS),
    .TREE_WORDS(TREE_WORDS), .SRCH_WORDS(SRCH_WORDS), .RES_WORDS(RES_WORDS),
    .TGT_W(TGT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_decode (
    .addr_word(addr_q), .hit(dec_hit), .tgt(dec_tgt),
    .nwords(dec_nwords), .entry(dec_entry)
  );

  assign host_wr  = reg_wr && !busy;
  assign cmd_wr   = host_wr && (reg_addr == ADDR_W'(OFF_CMD));
  assign cmd_good = (reg_wdata == OP_WRITE || reg_wdata == OP_READ) && dec_hit;
  assign start_wr = cmd_wr && cmd_good && (reg_wdata == OP_WRITE);
  assign start_rd = cmd_wr && cmd_good && (reg_wdata == OP_READ);

  indram_seq #(.CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS)) u_seq (
    .clk(clk), .rst(rst), .start_wr(start_wr), .start_rd(start_rd),
    .nwords(nwords_q), .busy(busy), .mem_we(seq_we), .mem_re(seq_re),
    .word_idx(word_idx), .lat_en(lat_en), .lat_idx(lat_idx), .done(done)
  );

  assign mem_addr = base_q + MEM_AW'(word_idx);
  assign rd_sel   = rd_arr[tgt_q];

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_mem
    localparam int WORDS_G = (g < NUM_PARSERS) ? PKT_WORDS :
                             (g == NUM_PARSERS) ? TREE_WORDS :
                             (g == NUM_PARSERS + 1) ? SRCH_WORDS : RES_WORDS;
    assign we_vec[g] = seq_we && (tgt_q == TGT_W'(g));
    indram_mem #(.WIDTH(32), .DEPTH(ENTRIES * WORDS_G), .AW(MEM_AW)) u_mem (
      .clk(clk), .we(we_vec[g]), .re(seq_re && (tgt_q == TGT_W'(g))),
      .addr(mem_addr), .wdata(data_q[word_idx]), .rdata(rd_arr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      cmd_q    <= '0;
      status_q <= '0;
      tgt_q    <= '0;
      nwords_q <= '0;
      base_q   <= '0;
      for (int j = 0; j < DATA_REGS; j++) data_q[j] <= '0;
    end else begin
      if (host_wr && reg_addr == ADDR_W'(OFF_ADDR)) addr_q <= reg_wdata;
      for (int j = 0; j < DATA_REGS; j++)
        if (host_wr && reg_addr == ADDR_W'(OFF_DATA + 4 * j)) data_q[j] <= reg_wdata;
      if (cmd_wr) begin
        cmd_q <= reg_wdata;
        if (cmd_good) begin
          status_q <= '0;
          tgt_q    <= dec_tgt;
          nwords_q <= dec_nwords;
          base_q   <= MEM_AW'(dec_entry) * MEM_AW'(dec_nwords);
        end else begin
          status_q <= ERR_FLAG | (reg_wdata & OP_KNOWN);
        end
      end
      if (done)   status_q <= cmd_q & OP_KNOWN;
      if (lat_en) data_q[lat_idx] <= rd_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      if (reg_addr == ADDR_W'(OFF_ADDR)) reg_rdata <= addr_q;
      if (reg_addr == ADDR_W'(OFF_CMD))  reg_rdata <= cmd_q;
      if (reg_addr == ADDR_W'(OFF_STAT)) reg_rdata <= status_q;
      for (int j = 0; j < DATA_REGS; j++)
        if (reg_addr == ADDR_W'(OFF_DATA + 4 * j)) reg_rdata <= data_q[j];
    end
  end

  // R5/R6: status stays clear for the whole transfer
  a_r5_status_clear_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (status_q == 32'h0));
  // R8/R9: an error status means no memory is being written
  a_r9_no_write_on_error: assert property (@(posedge clk) disable iff (rst)
    status_q[31] |-> (we_vec == '0));
  // R5/R6: a successful completion reports a single command bit
  a_r6_single_done_bit: assert property (@(posedge clk) disable iff (rst)
    !status_q[31] |-> $onehot0(status_q));
  // R11: host writes while busy leave address and command alone
  a_r11_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_q));
  a_r11_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cmd_q));
endmodule

// File: tb/indram_ctrl_bench.sv
module indram_ctrl_bench;
  localparam int NP = 3;
  localparam int NT = NP + 3;
  localparam int ENT = 16;
  localparam int NREG = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0;
  logic [31:0] model [NT][ENT][NREG];
  bit          valid [NT][ENT];
  logic [31:0] shadow [NREG];

  always #2.5 clk = ~clk;

  indram_ctrl u_indram_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic int words_of(int t);
    if (t < NP) return 4;
    if (t == NP) return 17;
    if (t == NP + 1) return 8;
    return 6;
  endfunction

  function automatic logic [31:0] addr_of(int t, int e);
    logic [3:0] k;
    k = (t < NP) ? 4'(4 * t) : 4'(12 + t - NP);
    return {k, 28'(e)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_done(input logic [31:0] mask, output logic [31:0] st, output int polls);
    polls = 0;
    st = '0;
    for (int i = 0; i < 40; i++) begin
      rd(8'h0C, st);
      polls++;
      if ((st & mask) != 0) break;
    end
  endtask

  task automatic load_regs(int n);
    for (int j = 0; j < n; j++) begin
      shadow[j] = $urandom;
      wr(8'(16 + 4 * j), shadow[j]);
    end
  endtask

  task automatic do_write(int t, int e, string req);
    logic [31:0] st; int p;
    wr(8'h04, addr_of(t, e));
    wr(8'h08, 32'h1);
    wait_done(32'h8000_0001, st, p);
    check(req, st, 32'h1);
    check("R10 write latency", (p <= words_of(t) + 2) ? 32'h1 : 32'h0, 32'h1);
    for (int j = 0; j < words_of(t); j++) model[t][e][j] = shadow[j];
    valid[t][e] = 1'b1;
  endtask

  task automatic do_read_check(int t, int e, string req);
    logic [31:0] st, v; int p;
    wr(8'h04, addr_of(t, e));
    wr(8'h08, 32'h2);
    wait_done(32'h8000_0002, st, p);
    check("R6 read status", st, 32'h2);
    check("R10 read latency", (p <= words_of(t) + 3) ? 32'h1 : 32'h0, 32'h1);
    for (int j = 0; j < words_of(t); j++) shadow[j] = model[t][e][j];
    for (int j = 0; j < NREG; j++) begin
      rd(8'(16 + 4 * j), v);
      check(req, v, shadow[j]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v, st;
    int p;
    void'($urandom(32'd2024));
    for (int j = 0; j < NREG; j++) shadow[j] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(8'h04, v); check("R1 addr", v, 0);
    rd(8'h08, v); check("R1 cmd", v, 0);
    rd(8'h0C, v); check("R1 status", v, 0);
    rd(8'h10, v); check("R1 data0", v, 0);
    rd(8'h50, v); check("R1 data16", v, 0);

    // R2 readback, unmapped offset, status write ignored
    wr(8'h04, 32'hE000_0005); rd(8'h04, v); check("R2 addr readback", v, 32'hE000_0005);
    wr(8'h00, 32'h1234_5678); rd(8'h00, v); check("R2 unmapped", v, 0);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); check("R2 status ignores writes", v, 0);
    wr(8'h54, 32'hABCD_0000); rd(8'h54, v); check("R2 past last data", v, 0);

    // R3/R4 each memory round trip
    for (int t = 0; t < NT; t++) begin
      load_regs(NREG);
      do_write(t, 5, "R5 write status");
      for (int j = 0; j < NREG; j++) shadow[j] = ~shadow[j];
      for (int j = 0; j < NREG; j++) wr(8'(16 + 4 * j), shadow[j]);
      do_read_check(t, 5, "R4 R3 roundtrip and R6 upper regs kept");
    end

    // R7 parser separation
    load_regs(4); do_write(0, 3, "R7 p0 write");
    load_regs(4); do_write(1, 3, "R7 p1 write");
    load_regs(4); do_write(2, 3, "R7 p2 write");
    do_read_check(0, 3, "R7 parser0 entry");
    do_read_check(1, 3, "R7 parser1 entry");

    // R8 unsupported commands
    load_regs(NREG);
    wr(8'h04, addr_of(NP, 5));
    wr(8'h08, 32'h8);  rd(8'h0C, v); check("R8 add code", v, 32'h8000_0008);
    wr(8'h08, 32'h10); rd(8'h0C, v); check("R8 delete code", v, 32'h8000_0010);
    wr(8'h08, 32'h20); rd(8'h0C, v); check("R8 search code", v, 32'h8000_0020);
    wr(8'h08, 32'h3);  rd(8'h0C, v); check("R8 mixed code", v, 32'h8000_0003);
    rd(8'h08, v); check("R2 cmd readback", v, 32'h3);
    do_read_check(NP, 5, "R8 memory unchanged");

    // R9 bad type and out-of-range entry
    load_regs(NREG);
    wr(8'h04, 32'h1000_0005); wr(8'h08, 32'h1);
    rd(8'h0C, v); check("R9 bad type", v, 32'h8000_0001);
    wr(8'h04, {4'hC, 28'd16}); wr(8'h08, 32'h1);
    rd(8'h0C, v); check("R9 entry past end", v, 32'h8000_0001);
    wr(8'h04, {4'hE, 28'h100_0000}); wr(8'h08, 32'h2);
    rd(8'h0C, v); check("R9 high index bits", v, 32'h8000_0002);
    do_read_check(NP, 0, "R9 node entry0 unchanged");
    do_read_check(NP, 5, "R9 node entry5 unchanged");

    // R11 writes ignored while busy
    load_regs(NREG);
    wr(8'h04, addr_of(NP, 7));
    wr(8'h08, 32'h1);
    wr(8'h04, 32'hE000_0001);
    wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h08, 32'h2);
    wait_done(32'h8000_0003, st, p);
    check("R11 status after busy writes", st, 32'h1);
    for (int j = 0; j < 17; j++) model[NP][7][j] = shadow[j];
    valid[NP][7] = 1'b1;
    rd(8'h04, v); check("R11 addr kept", v, addr_of(NP, 7));
    rd(8'h08, v); check("R11 cmd kept", v, 32'h1);
    rd(8'h10, v); check("R11 data kept", v, shadow[0]);
    do_read_check(NP, 7, "R11 entry written from old regs");

    // random traffic
    for (int i = 0; i < 30; i++) begin
      int t, e;
      t = int'($urandom_range(NT - 1));
      e = int'($urandom_range(ENT - 1));
      load_regs(words_of(t));
      do_write(t, e, "R5 random write");
      e = int'($urandom_range(ENT - 1));
      if (!valid[t][e]) e = int'($urandom_range(ENT - 1));
      if (valid[t][e]) do_read_check(t, e, "R6 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule